// File: doc/BRIEF.md
# Two-Tier Carry Lookahead Adder (16 bits)

This block adds two 16-bit unsigned operands and a single carry input, and returns a 16-bit sum with a carry output. It is purely combinational: there is no clock, no register and no handshake. The result settles once the operands have been stable for the depth of the logic. It suits any datapath that wants a short carry path without a pipeline stage.

Internally the operands are split into four nibble-wide groups. Every bit forms its own propagate signal, which is the OR of the two operand bits, and its own generate signal, which is their AND. One lookahead cell per group turns those signals into the group's internal carries and into a group propagate and group generate. A second instance of the same cell takes the four group signals and the external carry input. It produces the seed carries into bits 4, 8 and 12, and the final carry out. The lowest group draws its carries straight from the external carry input. Because propagate uses OR and not XOR, each sum bit is formed with the full-adder expression from its two operand bits and its incoming carry.

Top module: `cla_adder16`

## Requirements
- R1: For every operand pair and carry input, {carry_out, sum_out} equals opnd_a + opnd_b + carry_in taken as a 17-bit unsigned value.
- R2: With every bit in a full propagate state (for example opnd_a = 0xFFFF, opnd_b = 0x0000, carry_in = 1), the carry input travels through all 16 positions: sum_out = 0x0000 and carry_out = 1.
- R3: With both operands zero, sum_out equals carry_in in bit 0 with all other bits 0, and carry_out = 0.
- R4: A carry generated in the top bit of a group (bit 3, 7 or 11) appears exactly in the lowest bit of the next group (bit 4, 8 or 12) and nowhere else.
- R5: A carry entering a group whose bits all propagate leaves that group and reaches the next group, for example 0x0FFF + 0x0000 + 1 = 0x1000.
- R6: carry_out is 1 exactly when the true sum is 0x10000 or more; a sum of 0xFFFF or less leaves it 0.
- R7: The carry that leaves each group's own lookahead cell agrees with the seed carry that the second tier hands to the next group, and with carry_out for the top group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The adder is tried with zero operands, which show whether carry_in alone reaches bit 0 and nothing more. It is also tried with all-ones operands and carry_in set, which drive the longest propagate chain through both tiers. Single generates in bits 3, 7, 11 and 15 separate a correct hand-off at each group boundary from an off-by-one seed carry. Runs of ones that span whole groups show whether group propagate is formed. Alternating 0x5555/0xAAAA patterns put propagate without generate in every bit, and a random sweep against a behavioural sum catches any miswired product term.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // bits covered by one lookahead cell
  localparam int unsigned GRP_W   = 4;
  // number of groups; equals GRP_W so one cell serves the second tier
  localparam int unsigned NUM_GRP = GRP_W;
  localparam int unsigned WIDTH   = GRP_W * NUM_GRP;
endpackage

// File: rtl/cla_pg_bits.sv
module cla_pg_bits #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // propagate is inclusive OR; carry-in plays no part here
    assign prop[i] = a[i] | b[i];
    assign gen[i]  = a[i] & b[i];
  end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4 (
  input  logic [3:0] p,
  input  logic [3:0] g,
  input  logic       ci,
  output logic [3:0] carry,   // carry[i] is the carry into position i+1
  output logic       grp_p,
  output logic       grp_g
);
  assign carry[0] = g[0] | (p[0] & ci);
  assign carry[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
  assign carry[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                  | (p[2] & p[1] & p[0] & ci);
  assign carry[3] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                  | (p[3] & p[2] & p[1] & g[0])
                  | (p[3] & p[2] & p[1] & p[0] & ci);

  assign grp_p = p[0] & p[1] & p[2] & p[3];
  assign grp_g = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
               | (p[3] & p[2] & p[1] & g[0]);

  always_comb begin
    if (!$isunknown({p, g, ci})) begin
      // R2: a full propagate chain with carry in sets every carry
      assert_full_chain_R2: assert (!(grp_p && ci) || (carry == 4'hF));
      // R3: nothing generated and no carry in leaves every carry clear
      assert_no_source_R3: assert (!((g == 4'h0) && !ci) || (carry == 4'h0));
    end
  end
endmodule

// File: rtl/cla_sum_bits.sv
module cla_sum_bits #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = a[i] ^ b[i] ^ c[i];
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
(
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic        carry_in,
  output logic [15:0] sum_out,
  output logic        carry_out
);
  logic [WIDTH-1:0]   bit_p, bit_g, bit_c;
  logic [NUM_GRP-1:0] grp_p, grp_g;
  logic [GRP_W-1:0]   grp_c [NUM_GRP];
  logic [NUM_GRP-1:0] seed;
  logic [GRP_W-1:0]   tier_c;
  logic               top_p, top_g;

  cla_pg_bits #(.W(WIDTH)) u_pg (
    .a(opnd_a), .b(opnd_b), .prop(bit_p), .gen(bit_g)
  );

  // second tier: same cell, fed with group signals
  cla_lookahead4 u_tier2 (
    .p(grp_p), .g(grp_g), .ci(carry_in),
    .carry(tier_c), .grp_p(top_p), .grp_g(top_g)
  );

  assign seed      = {tier_c[NUM_GRP-2:0], carry_in};
  assign carry_out = tier_c[NUM_GRP-1];

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    cla_lookahead4 u_cell (
      .p(bit_p[k*GRP_W +: GRP_W]), .g(bit_g[k*GRP_W +: GRP_W]),
      .ci(seed[k]), .carry(grp_c[k]),
      .grp_p(grp_p[k]), .grp_g(grp_g[k])
    );
    for (genvar i = 0; i < GRP_W; i++) begin : g_c
      if (i == 0) begin : g_seed
        assign bit_c[k*GRP_W] = seed[k];
      end else begin : g_inner
        assign bit_c[k*GRP_W + i] = grp_c[k][i-1];
      end
    end
  end

  cla_sum_bits #(.W(WIDTH)) u_sum (
    .a(opnd_a), .b(opnd_b), .c(bit_c), .s(sum_out)
  );

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, carry_in})) begin
      // R1: result equals the arithmetic sum
      assert_exact_sum_R1: assert ({carry_out, sum_out}
        == ({1'b0, opnd_a} + {1'b0, opnd_b} + {16'h0, carry_in}));
      // R7: group cells and second tier agree on boundary carries
      assert_tier_agree_R7: assert (
        (grp_c[0][GRP_W-1] == seed[1]) && (grp_c[1][GRP_W-1] == seed[2]) &&
        (grp_c[2][GRP_W-1] == seed[3]) && (grp_c[3][GRP_W-1] == carry_out));
      // R6: carry out follows whole-word propagate/generate
      assert_word_carry_R6: assert (carry_out == (top_g | (top_p & carry_in)));
    end
  end
endmodule

// File: tb/cla_adder16_test.sv
module cla_adder16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        ci = 1'b0;
  logic [15:0] s;
  logic        co;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  cla_adder16 uut (
    .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum_out(s), .carry_out(co)
  );

  localparam int NV = 16;
  // {a, b, ci, expected {co, sum}}
  localparam logic [49:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 17'h00000},  // R3
    {16'h0000, 16'h0000, 1'b1, 17'h00001},  // R3
    {16'hFFFF, 16'h0000, 1'b1, 17'h10000},  // R2
    {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},  // R2
    {16'h0008, 16'h0008, 1'b0, 17'h00010},  // R4 bit3 -> bit4
    {16'h0080, 16'h0080, 1'b0, 17'h00100},  // R4 bit7 -> bit8
    {16'h0800, 16'h0800, 1'b0, 17'h01000},  // R4 bit11 -> bit12
    {16'h000F, 16'h0001, 1'b0, 17'h00010},  // R5
    {16'h0FFF, 16'h0000, 1'b1, 17'h01000},  // R5
    {16'h00FF, 16'h0000, 1'b1, 17'h00100},  // R5
    {16'h5555, 16'hAAAA, 1'b0, 17'h0FFFF},  // R1 alternating
    {16'h5555, 16'hAAAA, 1'b1, 17'h10000},  // R2 alternating chain
    {16'hAAAA, 16'hAAAA, 1'b0, 17'h15554},  // R1
    {16'h5555, 16'h5555, 1'b1, 17'h0AAAB},  // R1
    {16'h8000, 16'h8000, 1'b0, 17'h10000},  // R6
    {16'h7FFF, 16'h0001, 1'b0, 17'h08000}   // R6 no carry out
  };
  localparam int TAG [NV] = '{3, 3, 2, 2, 4, 4, 4, 5, 5, 5, 1, 2, 1, 1, 6, 6};

  task automatic apply(input logic [15:0] va, input logic [15:0] vb,
                       input logic vc, input logic [16:0] exp, input int tag);
    @(posedge clk);
    #1 a = va; b = vb; ci = vc;
    #2;
    n_vec++;
    if ({co, s} !== exp) begin
      n_bad++;
      $display("FAIL R%0d: %h+%h+%b got %h expected %h", tag, va, vb, vc,
               {co, s}, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1: watchdog expired got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R3: idle inputs after reset give a zero result
    apply(16'h0000, 16'h0000, 1'b0, 17'h00000, 3);

    for (int i = 0; i < NV; i++)
      apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:0], TAG[i]);

    // R4: single generate at each group top lands in the next group's bit 0
    for (int k = 0; k < 4; k++) begin
      logic [15:0] v = 16'h0008 << (4 * k);
      apply(v, v, 1'b0, {1'b0, v} << 1, 4);
    end
    // R5: carry in through 4, 8, 12 full-propagate bits
    for (int k = 1; k < 4; k++) begin
      logic [15:0] v = (16'h1 << (4 * k)) - 16'h1;
      apply(v, 16'h0000, 1'b1, {1'b0, v} + 17'h1, 5);
    end
    // R6: near the word boundary
    apply(16'hFFFF, 16'h0000, 1'b0, 17'h0FFFF, 6);
    apply(16'hFFFE, 16'h0001, 1'b1, 17'h10000, 6);

    // R1: random sweep against behavioural sum
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra = 16'($urandom);
      logic [15:0] rb = 16'($urandom);
      logic        rc = 1'($urandom);
      apply(ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {16'h0, rc}, 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule